// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block checks one memory reference against a 64-bit protected-mode segment descriptor. Each request carries the descriptor, a 32-bit offset, an access kind (read, write or execute), the current privilege level and the requested privilege level. The block answers with either a 32-bit linear address or a single encoded fault code.

The check scales the 20-bit limit by granularity. It applies an expand-up bound, or an expand-down bound whose ceiling is chosen by the big bit. It enforces the presence, descriptor-kind, privilege and read/write/execute rules, and these rights rules read the same descriptor bits differently for code and for data.

A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The result appears on the following cycle for exactly one cycle. On a successful access, the block also raises a one-cycle request to write the descriptor's accessed bit back as set.

Top module: `seg_access_check`

## Requirements
- R1: After reset `req_ready` is high from the first clock edge on. During reset `req_ready`, `rsp_valid`, `rsp_set_accessed`, `rsp_fault` and `rsp_lin_addr` are all zero. An accepted request gives `rsp_valid` high for exactly the next cycle, and a cycle without acceptance gives `rsp_valid` low on the next cycle.
- R2: The descriptor fields sit at fixed positions.
  - Upper word: base[31:24] at bits 63:56, granularity at 55, big/default at 54, limit[19:16] at 51:48, present at 47, privilege level at 46:45, descriptor kind at 44, code/data at 43, conforming/expand-down at 42, readable/writable at 41, accessed at 40, base[23:16] at 39:32.
  - Lower word: base[15:0] at bits 31:16 and limit[15:0] at bits 15:0.
  - Bits 53, 52 and 40 have no effect on the result.
- R3: With granularity clear, the effective limit is the 20-bit limit. With it set, the effective limit is the limit shifted left by 12 with the low 12 bits all ones.
- R4: For code segments and for data segments with bit 42 clear, an offset passes the bound check when it is at most the effective limit.
- R5: For a data segment with bit 42 set, an offset passes when it is above the effective limit and at most the ceiling. The ceiling is 0xFFFFFFFF when bit 54 is set and 0x0000FFFF when bit 54 is clear.
- R6: A descriptor with bit 44 clear gives fault code 1 (type), whatever the other bits hold.
- R7: A descriptor with bit 44 set and bit 47 clear gives fault code 2 (not present).
- R8: Privilege rules, where a failure gives fault code 3:
  - For data and non-conforming code, the larger of the current and requested levels must be at most the descriptor level.
  - For conforming code (bits 43 and 42 set), the descriptor level must be at most the current level.
- R9: Code segments may be executed, may be read only when bit 41 is set, and are never writable. A refused access gives fault code 4 (rights).
- R10: Data segments may be read, may be written only when bit 41 is set, and are never executable. A refused access gives fault code 4. Access kinds are encoded 0 read, 1 write, 2 execute; kind 3 is always refused with code 4.
- R11: With no fault (code 0), `rsp_lin_addr` is base plus offset modulo 2^32. With any fault it is zero.
- R12: `rsp_set_accessed` is high exactly on result cycles with fault code 0. This holds even when the accessed bit is already set.
- R13: A limit failure gives fault code 5. When several rules fail, the reported code is the first failing one in the order type, not present, privilege, rights, limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_desc | input | 64 | Segment descriptor |
| req_offset | input | 32 | Offset into the segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_cpl | input | 2 | Current privilege level |
| req_rpl | input | 2 | Requested privilege level |
| rsp_valid | output | 1 | Result present, one cycle after acceptance |
| rsp_fault | output | 3 | Fault code, 0 when the access succeeds |
| rsp_lin_addr | output | 32 | Linear address, zero on a fault |
| rsp_set_accessed | output | 1 | Write the accessed bit back as set |

## Verification
The bound check is probed on both sides of each edge:
- expand-up segments with byte and page granularity, which tells the two limit scalings apart;
- expand-down segments with a small and a big ceiling, which separates the lower bound from the ceiling;
- an offset near the top of the address space, which exposes the wrap of the base-plus-offset sum.

Privilege is tried with each level arrangement for data, non-conforming and conforming code, so a swapped comparison or a missing requested level shows up. Descriptors that fail two or more rules at once show whether the priority order holds. Setting the ignored bits confirms that they leave the result unchanged.

// File: rtl/segchk_pkg.sv
// Package: shared widths, access kinds, fault codes and the decoded
// descriptor record used by the segment access checker.
// Assumes a 32-bit linear address space and a 20-bit limit field.
package segchk_pkg;

    localparam int ADDR_W     = 32;
    localparam int LIMIT_W    = 20;
    localparam int PAGE_SHIFT = 12;
    localparam int PL_W       = 2;
    localparam int DESC_W     = 64;
    localparam int SMALL_W    = 16;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_TYPE   = 3'd1,
        FLT_ABSENT = 3'd2,
        FLT_PRIV   = 3'd3,
        FLT_RIGHTS = 3'd4,
        FLT_BOUND  = 3'd5
    } fault_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [LIMIT_W-1:0] limit;
        logic               gran;       // limit counts pages
        logic               big;        // large ceiling / default size
        logic               present;
        logic [PL_W-1:0]    dpl;
        logic               mem_kind;   // 1 = code/data, 0 = system
        logic               is_code;
        logic               conf_down;  // conforming (code) / expand-down (data)
        logic               rd_wr;      // readable (code) / writable (data)
    } seg_fields_t;

endpackage

// File: rtl/seg_desc_unpack.sv
// Module: seg_desc_unpack
// Pulls the fields out of a 64-bit descriptor and forms the effective
// byte limit from the raw limit and the granularity bit.
// Assumes LIMIT_W + PAGE_SHIFT equals ADDR_W, so a page-scaled limit
// fills the address width exactly.
module seg_desc_unpack
    import segchk_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int LW  = LIMIT_W,
    parameter int PGS = PAGE_SHIFT
) (
    input  logic [DESC_W-1:0] desc,
    output seg_fields_t       fields,
    output logic [AW-1:0]     eff_limit
);
    localparam int PAD_W = AW - LW;

    logic [AW-1:0] lim_bytes;
    logic [AW-1:0] lim_pages;
    logic          unused_desc_bits;

    // Field extraction from both descriptor words.
    always_comb begin
        fields.base      = {desc[63:56], desc[39:32], desc[31:16]};
        fields.limit     = {desc[51:48], desc[15:0]};
        fields.gran      = desc[55];
        fields.big       = desc[54];
        fields.present   = desc[47];
        fields.dpl       = desc[46:45];
        fields.mem_kind  = desc[44];
        fields.is_code   = desc[43];
        fields.conf_down = desc[42];
        fields.rd_wr     = desc[41];
    end

    // Long-mode flag, software bit and accessed bit do not affect the check.
    assign unused_desc_bits = ^{desc[53:52], desc[40]};

    // Limit in byte units and in page units (low page bits all ones).
    assign lim_bytes = {{PAD_W{1'b0}}, fields.limit};
    assign lim_pages = {fields.limit, {PGS{1'b1}}};

    // Granularity selects the scaling.
    assign eff_limit = fields.gran ? lim_pages : lim_bytes;

endmodule

// File: rtl/seg_bound_check.sv
// Module: seg_bound_check
// Decides whether an offset lies inside the segment, for either the
// expand-up or the expand-down layout.
// Assumes the caller clears expand_down for code segments.
module seg_bound_check
    import segchk_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int SMW = SMALL_W
) (
    input  logic [AW-1:0] offset,
    input  logic [AW-1:0] eff_limit,
    input  logic          expand_down,
    input  logic          big,
    output logic          in_bounds
);
    localparam logic [AW-1:0] SMALL_CEIL = {{(AW-SMW){1'b0}}, {SMW{1'b1}}};
    localparam logic [AW-1:0] BIG_CEIL   = {AW{1'b1}};

    logic [AW-1:0] ceiling;
    logic          up_ok;
    logic          down_ok;

    // Ceiling for expand-down segments, picked by the big bit.
    assign ceiling = big ? BIG_CEIL : SMALL_CEIL;

    // Both bound forms, then selection by layout.
    always_comb begin
        up_ok     = (offset <= eff_limit);
        down_ok   = (offset > eff_limit) && (offset <= ceiling);
        in_bounds = expand_down ? down_ok : up_ok;
    end

endmodule

// File: rtl/seg_rights_check.sv
// Module: seg_rights_check
// Evaluates the privilege rule and the read/write/execute rule for a
// code or data descriptor.
// Assumes the descriptor is a code/data one; the system case is
// rejected upstream.
module seg_rights_check
    import segchk_pkg::*;
#(
    parameter int PLW = PL_W
) (
    input  seg_fields_t    fields,
    input  logic [1:0]     kind,
    input  logic [PLW-1:0] cpl,
    input  logic [PLW-1:0] rpl,
    output logic           priv_ok,
    output logic           rights_ok
);
    logic [PLW-1:0] eff_pl;
    logic           conforming;

    // Weaker of the two requester levels (numerically larger).
    assign eff_pl     = (cpl > rpl) ? cpl : rpl;
    assign conforming = fields.is_code && fields.conf_down;

    // Privilege rule: conforming code compares against CPL only.
    always_comb begin
        if (conforming) priv_ok = (fields.dpl <= cpl);
        else            priv_ok = (eff_pl <= fields.dpl);
    end

    // Rights rule: the same bit means readable for code, writable for data.
    always_comb begin
        unique case (kind)
            ACC_READ:  rights_ok = fields.is_code ? fields.rd_wr : 1'b1;
            ACC_WRITE: rights_ok = fields.is_code ? 1'b0 : fields.rd_wr;
            ACC_EXEC:  rights_ok = fields.is_code;
            default:   rights_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/seg_access_check.sv
// Module: seg_access_check (top)
// Accepts a descriptor plus an access request, and one cycle later
// reports either a linear address or a prioritised fault code. Also
// raises a request to write the accessed bit back as set.
// Assumes requests arrive one per cycle at most; results are not
// back-pressured.
module seg_access_check
    import segchk_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int PLW = PL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [63:0]     req_desc,
    input  logic [AW-1:0]   req_offset,
    input  logic [1:0]      req_kind,
    input  logic [PLW-1:0]  req_cpl,
    input  logic [PLW-1:0]  req_rpl,
    output logic            rsp_valid,
    output logic [2:0]      rsp_fault,
    output logic [AW-1:0]   rsp_lin_addr,
    output logic            rsp_set_accessed
);
    seg_fields_t   fields;
    logic [AW-1:0] eff_limit;
    logic          in_bounds;
    logic          priv_ok;
    logic          rights_ok;
    logic          accept;
    fault_e        fault_nxt;
    logic [AW-1:0] addr_sum;

    seg_desc_unpack #(.AW(AW), .LW(LIMIT_W), .PGS(PAGE_SHIFT)) u_unpack (
        .desc      (req_desc),
        .fields    (fields),
        .eff_limit (eff_limit)
    );

    seg_bound_check #(.AW(AW), .SMW(SMALL_W)) u_bound (
        .offset      (req_offset),
        .eff_limit   (eff_limit),
        .expand_down (fields.conf_down && !fields.is_code),
        .big         (fields.big),
        .in_bounds   (in_bounds)
    );

    seg_rights_check #(.PLW(PLW)) u_rights (
        .fields    (fields),
        .kind      (req_kind),
        .cpl       (req_cpl),
        .rpl       (req_rpl),
        .priv_ok   (priv_ok),
        .rights_ok (rights_ok)
    );

    assign accept   = req_valid && req_ready;
    assign addr_sum = fields.base + req_offset;

    // Fault selection in fixed priority order.
    always_comb begin
        if (!fields.mem_kind)     fault_nxt = FLT_TYPE;
        else if (!fields.present) fault_nxt = FLT_ABSENT;
        else if (!priv_ok)        fault_nxt = FLT_PRIV;
        else if (!rights_ok)      fault_nxt = FLT_RIGHTS;
        else if (!in_bounds)      fault_nxt = FLT_BOUND;
        else                      fault_nxt = FLT_NONE;
    end

    // Ready rises on the first edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) req_ready <= 1'b0;
        else        req_ready <= 1'b1;
    end

    // Result register: loaded on acceptance, pulses valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid        <= 1'b0;
            rsp_fault        <= FLT_NONE;
            rsp_lin_addr     <= '0;
            rsp_set_accessed <= 1'b0;
        end else if (accept) begin
            rsp_valid        <= 1'b1;
            rsp_fault        <= fault_nxt;
            rsp_lin_addr     <= (fault_nxt == FLT_NONE) ? addr_sum : '0;
            rsp_set_accessed <= (fault_nxt == FLT_NONE);
        end else begin
            rsp_valid        <= 1'b0;
            rsp_set_accessed <= 1'b0;
        end
    end

endmodule

// File: rtl/seg_access_check_sva.sv
// Module: seg_access_check_sva
// Checker bound to seg_access_check; watches handshake timing, fault
// priority, rights invariants and the accessed-bit request.
module seg_access_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_desc,
    input logic [1:0]  req_kind,
    input logic        rsp_valid,
    input logic [2:0]  rsp_fault,
    input logic [31:0] rsp_lin_addr,
    input logic        rsp_set_accessed
);
    logic acc;
    assign acc = req_valid && req_ready;

    a_r1_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);
    a_r1_no_rsp_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);
    a_r6_system_desc_type_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_desc[44]) |=> (rsp_fault == 3'd1));
    a_r7_absent_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_desc[44] && !req_desc[47]) |=> (rsp_fault == 3'd2));
    a_r9_code_write_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_desc[43] && req_kind == 2'd1) |=> (rsp_fault != 3'd0));
    a_r10_data_exec_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_desc[43] && req_kind == 2'd2) |=> (rsp_fault != 3'd0));
    a_r11_fault_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_lin_addr == 32'd0));
    a_r12_accessed_only_success: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_set_accessed |-> (rsp_valid && rsp_fault == 3'd0));
    a_r12_success_sets_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 3'd0) |-> rsp_set_accessed);
    a_r13_fault_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault <= 3'd5);

endmodule

bind seg_access_check seg_access_check_sva u_sva (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .req_desc         (req_desc),
    .req_kind         (req_kind),
    .rsp_valid        (rsp_valid),
    .rsp_fault        (rsp_fault),
    .rsp_lin_addr     (rsp_lin_addr),
    .rsp_set_accessed (rsp_set_accessed)
);

// File: tb/seg_access_check_bench.sv
// Directed bench for seg_access_check: one task per scenario.
module seg_access_check_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_desc = '0;
    logic [31:0] req_offset = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_cpl = '0;
    logic [1:0]  req_rpl = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [31:0] rsp_lin_addr;
    logic        rsp_set_accessed;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seg_access_check u_seg_access_check (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_valid        (req_valid),
        .req_ready        (req_ready),
        .req_desc         (req_desc),
        .req_offset       (req_offset),
        .req_kind         (req_kind),
        .req_cpl          (req_cpl),
        .req_rpl          (req_rpl),
        .rsp_valid        (rsp_valid),
        .rsp_fault        (rsp_fault),
        .rsp_lin_addr     (rsp_lin_addr),
        .rsp_set_accessed (rsp_set_accessed)
    );

    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_EX = 2'd2;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Descriptor builder: fields placed as listed in R2.
    function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
                                       input logic g, input logic db, input logic p,
                                       input logic [1:0] dpl, input logic s, input logic code,
                                       input logic ce, input logic rw);
        logic [31:0] hi;
        logic [31:0] lo;
        hi = {base[31:24], g, db, 2'b00, lim[19:16], p, dpl, s, code, ce, rw, 1'b0, base[23:16]};
        lo = {base[15:0], lim[15:0]};
        return {hi, lo};
    endfunction

    // One request, result checked on the following cycle.
    task automatic access(input string tag, input logic [63:0] d, input logic [31:0] off,
                          input logic [1:0] k, input logic [1:0] cpl, input logic [1:0] rpl,
                          input logic [2:0] exp_fault);
        logic [31:0] exp_addr;
        @(negedge clk);
        req_desc = d; req_offset = off; req_kind = k; req_cpl = cpl; req_rpl = rpl;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        exp_addr = (exp_fault == 3'd0) ? ({d[63:56], d[39:32], d[31:16]} + off) : 32'd0;
        check({tag, " R1 valid"}, {31'd0, rsp_valid}, 32'd1);
        check({tag, " R13 fault"}, {29'd0, rsp_fault}, {29'd0, exp_fault});
        check({tag, " R11 addr"}, rsp_lin_addr, exp_addr);
        check({tag, " R12 accessed"}, {31'd0, rsp_set_accessed}, {31'd0, exp_fault == 3'd0});
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset ready", {31'd0, req_ready}, 32'd0);
        check("R1 reset valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 reset fault", {29'd0, rsp_fault}, 32'd0);
        check("R1 reset addr", rsp_lin_addr, 32'd0);
        check("R1 reset accessed", {31'd0, rsp_set_accessed}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic t_idle_and_pulse;
        logic [63:0] d;
        d = mk(32'h1234_5678, 20'h00FFF, 0, 1, 1, 2'd0, 1, 0, 0, 1);
        access("R2 field layout", d, 32'h10, K_RD, 2'd0, 2'd0, 3'd0);
        @(negedge clk);
        check("R1 valid one cycle", {31'd0, rsp_valid}, 32'd0);
        check("R12 accessed one cycle", {31'd0, rsp_set_accessed}, 32'd0);
        // Ignored bits 53, 52 and the accessed bit 40 set.
        access("R2 ignored bits", d | 64'h0030_0100_0000_0000, 32'h20, K_WR, 2'd0, 2'd0, 3'd0);
    endtask

    task automatic t_expand_up;
        logic [63:0] d;
        d = mk(32'h0001_0000, 20'h00FFF, 0, 1, 1, 2'd3, 1, 0, 0, 1);
        access("R4 up last byte", d, 32'h0FFF, K_RD, 2'd3, 2'd3, 3'd0);
        access("R4 up past limit", d, 32'h1000, K_RD, 2'd3, 2'd3, 3'd5);
        d = mk(32'h0001_0000, 20'h00FFF, 0, 1, 1, 2'd0, 1, 1, 0, 1);
        access("R4 code past limit", d, 32'h1000, K_EX, 2'd0, 2'd0, 3'd5);
    endtask

    task automatic t_granular;
        logic [63:0] d;
        d = mk(32'h0040_0000, 20'h00001, 1, 1, 1, 2'd0, 1, 0, 0, 1);
        access("R3 page last byte", d, 32'h1FFF, K_RD, 2'd0, 2'd0, 3'd0);
        access("R3 page past limit", d, 32'h2000, K_RD, 2'd0, 2'd0, 3'd5);
    endtask

    task automatic t_expand_down;
        logic [63:0] d;
        d = mk(32'h0000_8000, 20'h00FFF, 0, 0, 1, 2'd0, 1, 0, 1, 1);
        access("R5 down at limit", d, 32'h0FFF, K_RD, 2'd0, 2'd0, 3'd5);
        access("R5 down above limit", d, 32'h1000, K_RD, 2'd0, 2'd0, 3'd0);
        access("R5 small ceiling", d, 32'hFFFF, K_WR, 2'd0, 2'd0, 3'd0);
        access("R5 above small ceiling", d, 32'h1_0000, K_RD, 2'd0, 2'd0, 3'd5);
        d = mk(32'h0000_0100, 20'h00FFF, 0, 1, 1, 2'd0, 1, 0, 1, 1);
        access("R5 big ceiling mid", d, 32'h1_0000, K_RD, 2'd0, 2'd0, 3'd0);
        access("R5 big ceiling top wraps R11", d, 32'hFFFF_FFFF, K_RD, 2'd0, 2'd0, 3'd0);
    endtask

    task automatic t_type_present;
        access("R6 system desc", mk(32'h0, 20'hFFFFF, 0, 0, 0, 2'd0, 0, 0, 0, 0),
               32'h0, K_RD, 2'd0, 2'd0, 3'd1);
        access("R7 not present", mk(32'h0, 20'hFFFFF, 0, 0, 0, 2'd0, 1, 0, 0, 1),
               32'h0, K_RD, 2'd3, 2'd3, 3'd2);
    endtask

    task automatic t_privilege;
        access("R8 data dpl0 cpl3", mk(32'h100, 20'hFFFFF, 0, 1, 1, 2'd0, 1, 0, 0, 1),
               32'h4, K_RD, 2'd3, 2'd0, 3'd3);
        access("R8 data rpl weaker", mk(32'h100, 20'hFFFFF, 0, 1, 1, 2'd2, 1, 0, 0, 1),
               32'h4, K_RD, 2'd0, 2'd3, 3'd3);
        access("R8 data dpl3 ok", mk(32'h100, 20'hFFFFF, 0, 1, 1, 2'd3, 1, 0, 0, 1),
               32'h4, K_RD, 2'd0, 2'd3, 3'd0);
        access("R8 nonconf rpl1", mk(32'h100, 20'hFFFFF, 0, 1, 1, 2'd0, 1, 1, 0, 1),
               32'h4, K_EX, 2'd0, 2'd1, 3'd3);
        access("R8 conforming from ring3", mk(32'h100, 20'hFFFFF, 0, 1, 1, 2'd0, 1, 1, 1, 1),
               32'h4, K_EX, 2'd3, 2'd3, 3'd0);
        access("R8 conforming dpl above cpl", mk(32'h100, 20'hFFFFF, 0, 1, 1, 2'd3, 1, 1, 1, 1),
               32'h4, K_EX, 2'd0, 2'd0, 3'd3);
    endtask

    task automatic t_rights;
        logic [63:0] cx, cr, dr, dw;
        cx = mk(32'h2000, 20'hFFFFF, 0, 1, 1, 2'd0, 1, 1, 0, 0);
        cr = mk(32'h2000, 20'hFFFFF, 0, 1, 1, 2'd0, 1, 1, 0, 1);
        dr = mk(32'h2000, 20'hFFFFF, 0, 1, 1, 2'd0, 1, 0, 0, 0);
        dw = mk(32'h2000, 20'hFFFFF, 0, 1, 1, 2'd0, 1, 0, 0, 1);
        access("R9 code exec", cx, 32'h8, K_EX, 2'd0, 2'd0, 3'd0);
        access("R9 code read unreadable", cx, 32'h8, K_RD, 2'd0, 2'd0, 3'd4);
        access("R9 code read readable", cr, 32'h8, K_RD, 2'd0, 2'd0, 3'd0);
        access("R9 code write", cr, 32'h8, K_WR, 2'd0, 2'd0, 3'd4);
        access("R10 data read", dr, 32'h8, K_RD, 2'd0, 2'd0, 3'd0);
        access("R10 data write ro", dr, 32'h8, K_WR, 2'd0, 2'd0, 3'd4);
        access("R10 data exec", dw, 32'h8, K_EX, 2'd0, 2'd0, 3'd4);
        access("R10 kind 3", dw, 32'h8, 2'd3, 2'd0, 2'd0, 3'd4);
    endtask

    task automatic t_priority;
        access("R13 priv over rights/limit", mk(32'h0, 20'h0000F, 0, 1, 1, 2'd0, 1, 0, 0, 0),
               32'h100, K_WR, 2'd3, 2'd3, 3'd3);
        access("R13 rights over limit", mk(32'h0, 20'h0000F, 0, 1, 1, 2'd3, 1, 0, 0, 0),
               32'h100, K_WR, 2'd0, 2'd0, 3'd4);
        access("R13 absent over priv", mk(32'h0, 20'h0000F, 0, 1, 0, 2'd0, 1, 0, 0, 0),
               32'h100, K_WR, 2'd3, 2'd3, 3'd2);
    endtask

    initial begin
        t_reset();
        t_idle_and_pulse();
        t_expand_up();
        t_granular();
        t_expand_down();
        t_type_present();
        t_privilege();
        t_rights();
        t_priority();
        done = 1'b1;
    end

    initial begin
        int cyc;
        for (cyc = 0; cyc < 20000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=running expected=finished");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule